// File: doc/BRIEF.md
# H-Bridge Control and Fault Latch

This block is the digital control core of a full-bridge motor driver. Two direction inputs select how the two half-bridge legs are driven: forward, reverse, or one of two freewheel states in which both legs sit at the same rail. Two disable inputs can force both legs to tristate. A mode input, `code_i`, decides whether those disable inputs are honoured at all, and which pins clear a stored fault.

Fault indications reach the block as clean digital levels: supply undervoltage, overtemperature, high-side overcurrent, low-side overcurrent and a current-limit chop request. Undervoltage releases the bridge as soon as the supply is back. Overtemperature and overcurrent are stored, and only a specific clearing edge removes them. That edge is taken from the disable pins when `code_i` is low and from the direction pins when `code_i` is high. An active-low status flag reports undervoltage, a stored fault, and an active disable.

Every input passes through a two-flop synchroniser before it is decoded or edge-detected. Each leg is driven with a 2-bit code that cannot request both transistors of one leg at the same time.

Top module: `hbridge_ctrl`

## Requirements
- R1: Leg codes are 00 tristate, 01 low and 10 high, and 11 never appears. In normal operation dir_a=1, dir_b=0 gives leg_a=10, leg_b=01 (forward), and dir_a=0, dir_b=1 gives leg_a=01, leg_b=10 (reverse), with flag_no=1.
- R2: In normal operation both direction inputs low drive both legs 01, and both high drive both legs 10, with flag_no=1.
- R3: With code_i=0, dis_a_i=1 or dis_b_i=0 puts both legs at 00 and drives flag_no=0.
- R4: With code_i=1, the disable inputs have no effect on the legs or the flag.
- R5: While uv_i=1 both legs are 00 and flag_no=0. When uv_i returns to 0, normal operation resumes with no other action.
- R6: A pulse on ot_i, oc_hs_i or oc_ls_i stores a fault. Both legs stay at 00 and flag_no=0 after the fault input has gone, whatever the other inputs do.
- R7: With code_i=0, a stored fault clears on a falling edge of dis_a_i or a rising edge of dis_b_i. Edges on the direction inputs do not clear it.
- R8: With code_i=1, a stored fault clears on a falling edge of dir_a_i or a rising edge of dir_b_i. Edges on the disable inputs do not clear it.
- R9: A clearing edge that arrives while ot_i is still high, or in the same cycle that a fault input rises, leaves the fault stored.
- R10: ilim_i=1 puts both legs at 00 with flag_no=1.
- R11: Priority is undervoltage, then stored fault, then current limit, then disable, then the direction decode. The flag follows the condition that wins, so a current limit that masks an active disable leaves flag_no=1.
- R12: Synchroniser reset values match open inputs: direction high, dis_a high, dis_b low, code low. During reset and right after it, both legs are 00 and flag_no=0.
- R13: A change on a direction input reaches the legs exactly two rising clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_a_i | input | 1 | Direction input for leg A |
| dir_b_i | input | 1 | Direction input for leg B |
| dis_a_i | input | 1 | Disable, active high |
| dis_b_i | input | 1 | Disable, active low |
| code_i | input | 1 | Mode select: 0 honours the disables and clears on them; 1 ignores the disables and clears on the direction inputs |
| uv_i | input | 1 | Undervoltage indication |
| ot_i | input | 1 | Overtemperature indication |
| oc_hs_i | input | 1 | High-side overcurrent indication |
| oc_ls_i | input | 1 | Low-side overcurrent indication |
| ilim_i | input | 1 | Current-limit chop request |
| leg_a_o | output | 2 | Leg A drive code |
| leg_b_o | output | 2 | Leg B drive code |
| flag_no | output | 1 | Status flag, active low |

## Verification
The case that needs care is a fault setting and a clearing edge arriving in the same cycle. The bench provokes it by raising ot_i in the same cycle as a rising edge on dir_b_i while code_i=1 and a fault is already stored. Both signals pass through identical synchronisers, so they reach the latch together. The test passes only if the legs stay tristate and the flag stays low afterwards. A related case holds ot_i high through a clearing edge and then drops it with no further edge; the fault must still be stored.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_TRI = 2'b00,
    LEG_LO  = 2'b01,
    LEG_HI  = 2'b10
  } leg_t;

  typedef enum logic [2:0] {
    MODE_UV,
    MODE_LATCH,
    MODE_ILIM,
    MODE_DIS,
    MODE_RUN
  } mode_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int                WIDTH   = 1,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hb_clear_edge.sv
module hb_clear_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic code_i,
  input  logic dir_a_i,
  input  logic dir_b_i,
  input  logic dis_a_i,
  input  logic dis_b_i,
  output logic clr_o
);
  logic dir_a_q, dir_b_q, dis_a_q, dis_b_q;
  logic dir_clr, dis_clr;

  // reset to open-pin levels so reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dir_a_q <= 1'b1;
      dir_b_q <= 1'b1;
      dis_a_q <= 1'b1;
      dis_b_q <= 1'b0;
    end else begin
      dir_a_q <= dir_a_i;
      dir_b_q <= dir_b_i;
      dis_a_q <= dis_a_i;
      dis_b_q <= dis_b_i;
    end

  assign dir_clr = (dir_a_q & ~dir_a_i) | (~dir_b_q & dir_b_i);
  assign dis_clr = (dis_a_q & ~dis_a_i) | (~dis_b_q & dis_b_i);
  assign clr_o   = code_i ? dir_clr : dis_clr;
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hot_i,
  input  logic clr_edge_i,
  output logic latched_o
);
  logic latched_q;

  // set beats clear; an edge while still hot does not clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       latched_q <= 1'b0;
    else if (set_i)                    latched_q <= 1'b1;
    else if (clr_edge_i && !hot_i)     latched_q <= 1'b0;

  assign latched_o = latched_q;

  assert_set_stores_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> latched_o);
  assert_hot_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && hot_i) |=> latched_o);
  assert_no_edge_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && !clr_edge_i) |=> latched_o);
endmodule

// File: rtl/hb_leg_drive.sv
module hb_leg_drive
  import hb_pkg::*;
(
  input  logic drive_i,
  input  logic level_i,
  output leg_t leg_o
);
  always_comb begin
    if (!drive_i)     leg_o = LEG_TRI;
    else if (level_i) leg_o = LEG_HI;
    else              leg_o = LEG_LO;
  end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_a_i,
  input  logic       dir_b_i,
  input  logic       dis_a_i,
  input  logic       dis_b_i,
  input  logic       code_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic       oc_hs_i,
  input  logic       oc_ls_i,
  input  logic       ilim_i,
  output logic [1:0] leg_a_o,
  output logic [1:0] leg_b_o,
  output logic       flag_no
);
  localparam int NUM_IN = 10;
  localparam int LEGS   = 2;
  // bit order: ilim oc_ls oc_hs ot uv code dis_b dis_a dir_b dir_a
  localparam logic [NUM_IN-1:0] OPEN_VAL = 10'b00000_00111;

  logic [NUM_IN-1:0] raw, syn;
  logic dir_a_s, dir_b_s, dis_a_s, dis_b_s, code_s;
  logic uv_s, ot_s, oc_s, ilim_s;
  logic clr_edge, latched, disabled;
  mode_t mode;
  logic [LEGS-1:0] level;
  leg_t leg [LEGS];

  assign raw = {ilim_i, oc_ls_i, oc_hs_i, ot_i, uv_i, code_i, dis_b_i, dis_a_i, dir_b_i, dir_a_i};

  hb_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(OPEN_VAL)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign dir_a_s = syn[0];
  assign dir_b_s = syn[1];
  assign dis_a_s = syn[2];
  assign dis_b_s = syn[3];
  assign code_s  = syn[4];
  assign uv_s    = syn[5];
  assign ot_s    = syn[6];
  assign oc_s    = syn[7] | syn[8];
  assign ilim_s  = syn[9];

  hb_clear_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (code_s),
    .dir_a_i(dir_a_s),
    .dir_b_i(dir_b_s),
    .dis_a_i(dis_a_s),
    .dis_b_i(dis_b_s),
    .clr_o  (clr_edge)
  );

  hb_fault_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ot_s | oc_s),
    .hot_i     (ot_s),
    .clr_edge_i(clr_edge),
    .latched_o (latched)
  );

  assign disabled = !code_s && (dis_a_s || !dis_b_s);

  always_comb begin
    if (uv_s)          mode = MODE_UV;
    else if (latched)  mode = MODE_LATCH;
    else if (ilim_s)   mode = MODE_ILIM;
    else if (disabled) mode = MODE_DIS;
    else               mode = MODE_RUN;
  end

  assign level = {dir_b_s, dir_a_s};

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hb_leg_drive u_drive (
      .drive_i(mode == MODE_RUN),
      .level_i(level[g]),
      .leg_o  (leg[g])
    );
  end

  assign leg_a_o = leg[0];
  assign leg_b_o = leg[1];
  assign flag_no = (mode == MODE_RUN) || (mode == MODE_ILIM);

  assert_leg_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leg_a_o != 2'b11) && (leg_b_o != 2'b11));
  assert_uv_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_s |-> (leg_a_o == 2'b00 && leg_b_o == 2'b00 && !flag_no));
  assert_latch_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched |-> (leg_a_o == 2'b00 && leg_b_o == 2'b00 && !flag_no));
  assert_code_ignores_dis_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_s && !uv_s && !latched && !ilim_s) |-> (flag_no && leg_a_o != 2'b00));
  assert_ilim_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilim_s && !uv_s && !latched) |-> (flag_no && leg_a_o == 2'b00 && leg_b_o == 2'b00));
endmodule

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 1'b1, dir_b = 1'b0, dis_a = 1'b0, dis_b = 1'b1, code = 1'b0;
  logic uv = 1'b0, ot = 1'b0, oc_hs = 1'b0, oc_ls = 1'b0, ilim = 1'b0;
  logic [1:0] leg_a, leg_b;
  logic flag_n;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hbridge_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_a_i(dir_a), .dir_b_i(dir_b),
    .dis_a_i(dis_a), .dis_b_i(dis_b), .code_i(code), .uv_i(uv), .ot_i(ot),
    .oc_hs_i(oc_hs), .oc_ls_i(oc_ls), .ilim_i(ilim),
    .leg_a_o(leg_a), .leg_b_o(leg_b), .flag_no(flag_n)
  );

  localparam logic [1:0] TRI = 2'b00, LO = 2'b01, HI = 2'b10;

  // expected {leg_a, leg_b, flag_n} by the priority of R11
  function automatic logic [4:0] expect_out(logic da, logic db, logic xa, logic xb,
                                            logic cd, logic u, logic lat, logic il);
    if (u || lat)               return {TRI, TRI, 1'b0};
    if (il)                     return {TRI, TRI, 1'b1};
    if (!cd && (xa || !xb))     return {TRI, TRI, 1'b0};
    return {da ? HI : LO, db ? HI : LO, 1'b1};
  endfunction

  task automatic chk(string req, logic [4:0] exp);
    checks++;
    if ({leg_a, leg_b, flag_n} !== exp) begin
      errors++;
      $display("FAIL %s: got leg_a=%b leg_b=%b flag_n=%b, expected leg_a=%b leg_b=%b flag_n=%b",
               req, leg_a, leg_b, flag_n, exp[4:3], exp[2:1], exp[0]);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: got hang, expected completion");
    summary();
  end

  initial begin
    // R12: open-pin reset defaults hold during and right after reset
    repeat (3) @(negedge clk);
    chk("R12", {TRI, TRI, 1'b0});
    rst_n = 1'b1;
    chk("R12", {TRI, TRI, 1'b0});
    settle();
    chk("R1", {HI, LO, 1'b1});

    // R1 R2 R3 R4: sweep of direction, disable and mode with no faults
    for (int v = 0; v < 32; v++) begin
      {code, dis_b, dis_a, dir_b, dir_a} = 5'(v);
      settle();
      if (!code && (dis_a || !dis_b))      chk("R3", expect_out(dir_a, dir_b, dis_a, dis_b, code, 0, 0, 0));
      else if (code && (dis_a || !dis_b))  chk("R4", expect_out(dir_a, dir_b, dis_a, dis_b, code, 0, 0, 0));
      else if (dir_a != dir_b)             chk("R1", expect_out(dir_a, dir_b, dis_a, dis_b, code, 0, 0, 0));
      else                                 chk("R2", expect_out(dir_a, dir_b, dis_a, dis_b, code, 0, 0, 0));
    end

    // R10 R11: current limit over the same sweep
    ilim = 1'b1;
    for (int v = 0; v < 32; v++) begin
      {code, dis_b, dis_a, dir_b, dir_a} = 5'(v);
      settle();
      if (!code && (dis_a || !dis_b)) chk("R11", expect_out(dir_a, dir_b, dis_a, dis_b, code, 0, 0, 1));
      else                            chk("R10", expect_out(dir_a, dir_b, dis_a, dis_b, code, 0, 0, 1));
    end

    // R5 R11: undervoltage beats current limit, then self recovery
    {code, dis_b, dis_a, dir_b, dir_a} = 5'b01001;
    uv = 1'b1;
    settle();
    chk("R11", {TRI, TRI, 1'b0});
    ilim = 1'b0;
    settle();
    chk("R5", {TRI, TRI, 1'b0});
    uv = 1'b0;
    settle();
    chk("R5", {HI, LO, 1'b1});

    // R13: two-edge latency on a direction change
    {dir_b, dir_a} = 2'b10;
    @(negedge clk);
    chk("R13", {HI, LO, 1'b1});
    @(negedge clk);
    chk("R13", {LO, HI, 1'b1});
    {dir_b, dir_a} = 2'b01;
    settle();

    // R6 R7: overtemperature stored, cleared by dis_a falling edge (code=0)
    ot = 1'b1; settle(); ot = 1'b0; settle();
    chk("R6", {TRI, TRI, 1'b0});
    dir_a = 1'b0; settle(); dir_a = 1'b1; dir_b = 1'b1; settle(); dir_b = 1'b0; settle();
    chk("R7", {TRI, TRI, 1'b0});
    dis_a = 1'b1; settle(); dis_a = 1'b0; settle();
    chk("R7", {HI, LO, 1'b1});

    // R6 R7: high-side overcurrent cleared by dis_b rising edge
    oc_hs = 1'b1; settle(); oc_hs = 1'b0; settle();
    chk("R6", {TRI, TRI, 1'b0});
    dis_b = 1'b0; settle(); dis_b = 1'b1; settle();
    chk("R7", {HI, LO, 1'b1});

    // R6 R8: low-side overcurrent, code=1, disable edges ignored, dir_b rise clears
    oc_ls = 1'b1; settle(); oc_ls = 1'b0; code = 1'b1; settle();
    chk("R6", {TRI, TRI, 1'b0});
    dis_a = 1'b1; settle(); dis_a = 1'b0; dis_b = 1'b0; settle(); dis_b = 1'b1; settle();
    chk("R8", {TRI, TRI, 1'b0});
    dir_b = 1'b1; settle();
    chk("R8", {HI, HI, 1'b1});

    // R8: dir_a falling edge clears
    ot = 1'b1; settle(); ot = 1'b0; settle();
    chk("R6", {TRI, TRI, 1'b0});
    dir_a = 1'b0; settle();
    chk("R8", {LO, HI, 1'b1});

    // R9: clearing edge while still hot keeps fault
    dir_b = 1'b0; ot = 1'b1; settle();
    dir_b = 1'b1; settle();
    chk("R9", {TRI, TRI, 1'b0});
    ot = 1'b0; settle();
    chk("R9", {TRI, TRI, 1'b0});
    // R9: fault rising in the same cycle as a clearing edge
    dir_b = 1'b0; settle();
    dir_b = 1'b1; ot = 1'b1; settle();
    ot = 1'b0; settle();
    chk("R9", {TRI, TRI, 1'b0});
    dir_b = 1'b0; settle(); dir_b = 1'b1; settle();
    chk("R8", {LO, HI, 1'b1});

    summary();
  end
endmodule